// File: doc/BRIEF.md
# Timestamp Interval Compliance Monitor

This block watches the timing events of a multiplexed media stream and reports when they break the spacing and pairing rules that let a receiver lock its clock and schedule decoding. An upstream parser raises one-cycle strobes when it sees a transport-level clock reference, a stream-level clock reference, a presentation stamp, a decode stamp or the start of an access unit. A separate enable marks each tick of a 90 kHz time base. The monitor measures the time between events of each kind in these ticks and compares each gap with a limit held in a writable register.

Three interval timers run side by side. One is for transport clock references, with a default limit of 9000 ticks (100 ms). One is for stream clock references, with a default of 63000 ticks (700 ms). One is for presentation or decode stamps, also 63000 ticks. Two pairing checks catch a decode stamp that arrives without a presentation stamp and an access unit that starts with no stamp at all. Each of the five violation kinds has a sticky flag and a saturating counter. The flags are cleared by a strobe and the counters only by reset.

Top module: `ts_gap_monitor`

## Requirements
- R1: After synchronous reset all five flags and all five counters read zero, every interval timer is unarmed, and the three limits hold their default values.
- R2: Once a transport clock reference has been seen, the tick that makes the elapsed count reach limit+1 with no new reference sets flag bit 0. A reference that arrives in that same cycle or earlier restarts the interval at zero, and no violation is raised.
- R3: The same rule applies to stream clock references, using their own limit and flag bit 1.
- R4: A presentation stamp or a decode stamp restarts the stamp interval. Going past the stamp limit sets flag bit 2.
- R5: A decode-stamp strobe with no presentation-stamp strobe in the same cycle sets flag bit 3.
- R6: An access-unit strobe with neither a presentation-stamp nor a decode-stamp strobe in the same cycle sets flag bit 4.
- R7: The default limits are 9000, 63000 and 63000 ticks. When cfg_we is high, cfg_sel picks the register that loads cfg_data: 0 selects the transport reference, 1 the stream reference and 2 the stamp. The new limit takes effect from the next cycle. A write with cfg_sel = 3 changes nothing.
- R8: No interval violation of a kind occurs before the first event of that kind. Elapsed time advances only in cycles where tick_en is high.
- R9: An overdue interval raises exactly one violation, not one on every later tick.
- R10: Flags stay set until flag_clr. If a violation and flag_clr fall in the same cycle, the flag ends up set.
- R11: Each kind's counter, at viol_cnt bits [k*VCNT_W +: VCNT_W] for flag bit k, adds one per violation, stops at 2^VCNT_W-1 and is not affected by flag_clr.
- R12: Flags and counters change on the clock edge after the cycle that holds the triggering strobe or tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One 90 kHz time-base tick |
| tref_ev | input | 1 | Transport clock reference seen |
| sref_ev | input | 1 | Stream clock reference seen |
| pres_ev | input | 1 | Presentation stamp seen |
| dec_ev | input | 1 | Decode stamp seen |
| unit_ev | input | 1 | Access-unit start seen |
| flag_clr | input | 1 | Clears all sticky flags |
| cfg_we | input | 1 | Limit register write enable |
| cfg_sel | input | 2 | Limit register select |
| cfg_data | input | LIM_W | Limit value in ticks |
| viol_flag | output | 5 | Sticky violation flags, one bit per kind |
| viol_cnt | output | 5*VCNT_W | Saturating violation counters, packed by kind |

## Verification
On every cycle, assertions check several properties: each interval timer raises at most one violation in a row, it stays armed once armed, a flag holds until cleared, a counter only steps by one or holds at its ceiling, and a lone decode stamp or a bare unit start sets its flag on the next edge. Some behaviour can only be shown by the bench scenarios. These are the exact tick on which each limit is crossed, both with the reset defaults and with small written limits swept gap by gap; a restart in the cycle of the crossing tick; the ignored register select; all eight pairings of stamp and unit strobes; and counter saturation.

// File: rtl/ts_gap_pkg.sv
package ts_gap_pkg;

    localparam int NKIND = 5;
    localparam int NIVL  = 3;

    typedef enum int {
        K_TREF      = 0,
        K_SREF      = 1,
        K_STAMP     = 2,
        K_DEC_ALONE = 3,
        K_BARE_UNIT = 4
    } viol_kind_e;

    typedef struct packed {
        logic tref;
        logic sref;
        logic pres;
        logic dec;
        logic unit;
    } ts_events_t;

    function automatic logic stamp_seen(ts_events_t e);
        return e.pres | e.dec;
    endfunction

endpackage

// File: rtl/ts_gap_limits.sv
module ts_gap_limits #(
    parameter int LIM_W     = 16,
    parameter int TREF_DEF  = 9000,
    parameter int SREF_DEF  = 63000,
    parameter int STAMP_DEF = 63000
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [1:0]                          sel,
    input  logic [LIM_W-1:0]                    data,
    output logic [ts_gap_pkg::NIVL-1:0][LIM_W-1:0] lim
);
    import ts_gap_pkg::*;

    localparam logic [NIVL-1:0][LIM_W-1:0] DEFS =
        {LIM_W'(STAMP_DEF), LIM_W'(SREF_DEF), LIM_W'(TREF_DEF)};

    for (genvar g = 0; g < NIVL; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                lim[g] <= DEFS[g];
            else if (we && sel == 2'(g))
                lim[g] <= data;
        end
    end

endmodule

// File: rtl/ts_gap_interval.sv
module ts_gap_interval #(
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ev,
    input  logic [LIM_W-1:0] limit,
    output logic             viol
);
    logic             armed;
    logic             overdue;
    logic [LIM_W-1:0] elapsed;

    always_comb
        viol = armed && !overdue && tick && !ev && (elapsed >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            overdue <= 1'b0;
            elapsed <= '0;
        end else if (ev) begin
            armed   <= 1'b1;
            overdue <= 1'b0;
            elapsed <= '0;
        end else if (armed && tick && !overdue) begin
            elapsed <= elapsed + 1'b1;
            if (viol)
                overdue <= 1'b1;
        end
    end

    AST_ONCE_PER_GAP: assert property (@(posedge clk) disable iff (rst)
        viol |=> !viol); // R9

    AST_ARM_HOLD: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed); // R8

endmodule

// File: rtl/ts_gap_combo.sv
module ts_gap_combo (
    input  logic pres,
    input  logic dec,
    input  logic unit,
    output logic dec_alone,
    output logic bare_unit
);
    always_comb begin
        dec_alone = dec && !pres;
        bare_unit = unit && !(pres || dec);
    end
endmodule

// File: rtl/ts_gap_tally.sv
module ts_gap_tally #(
    parameter int VCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              clr,
    output logic              flag,
    output logic [VCNT_W-1:0] cnt
);
    localparam logic [VCNT_W-1:0] CEIL = {VCNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            cnt  <= '0;
        end else begin
            if (hit)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
            if (hit && cnt != CEIL)
                cnt <= cnt + 1'b1;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R10

    AST_CNT_CEIL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt == CEIL) |=> (cnt == CEIL)); // R11

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1)); // R11

endmodule

// File: rtl/ts_gap_monitor.sv
module ts_gap_monitor #(
    parameter int LIM_W     = 16,
    parameter int VCNT_W    = 8,
    parameter int TREF_DEF  = 9000,
    parameter int SREF_DEF  = 63000,
    parameter int STAMP_DEF = 63000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_en,
    input  logic                    tref_ev,
    input  logic                    sref_ev,
    input  logic                    pres_ev,
    input  logic                    dec_ev,
    input  logic                    unit_ev,
    input  logic                    flag_clr,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [LIM_W-1:0]        cfg_data,
    output logic [4:0]              viol_flag,
    output logic [5*VCNT_W-1:0]     viol_cnt
);
    import ts_gap_pkg::*;

    ts_events_t                   evs;
    logic [NIVL-1:0]              ivl_ev;
    logic [NIVL-1:0][LIM_W-1:0]   lim;
    logic [NKIND-1:0]             hits;

    always_comb begin
        evs = '{tref: tref_ev, sref: sref_ev, pres: pres_ev,
                dec: dec_ev, unit: unit_ev};
        ivl_ev[K_TREF]  = evs.tref;
        ivl_ev[K_SREF]  = evs.sref;
        ivl_ev[K_STAMP] = stamp_seen(evs);
    end

    ts_gap_limits #(
        .LIM_W(LIM_W), .TREF_DEF(TREF_DEF),
        .SREF_DEF(SREF_DEF), .STAMP_DEF(STAMP_DEF)
    ) u_limits (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
        .data(cfg_data), .lim(lim)
    );

    for (genvar g = 0; g < NIVL; g++) begin : g_ivl
        ts_gap_interval #(.LIM_W(LIM_W)) u_ivl (
            .clk(clk), .rst(rst), .tick(tick_en), .ev(ivl_ev[g]),
            .limit(lim[g]), .viol(hits[g])
        );
    end

    ts_gap_combo u_combo (
        .pres(evs.pres), .dec(evs.dec), .unit(evs.unit),
        .dec_alone(hits[K_DEC_ALONE]), .bare_unit(hits[K_BARE_UNIT])
    );

    for (genvar k = 0; k < NKIND; k++) begin : g_tally
        ts_gap_tally #(.VCNT_W(VCNT_W)) u_tally (
            .clk(clk), .rst(rst), .hit(hits[k]), .clr(flag_clr),
            .flag(viol_flag[k]), .cnt(viol_cnt[k*VCNT_W +: VCNT_W])
        );
    end

    AST_DEC_ALONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (dec_ev && !pres_ev) |=> viol_flag[K_DEC_ALONE]); // R5

    AST_BARE_UNIT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (unit_ev && !pres_ev && !dec_ev) |=> viol_flag[K_BARE_UNIT]); // R6

    AST_NO_TICK_NO_GAP_VIOL: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !flag_clr) |=> ($past(viol_flag[2:0]) == viol_flag[2:0])); // R8

endmodule

// File: tb/ts_gap_monitor_bench.sv
module ts_gap_monitor_bench;
    localparam int LW = 16;
    localparam int VW = 8;
    localparam logic [4:0] EV_TREF = 5'b10000;
    localparam logic [4:0] EV_SREF = 5'b01000;
    localparam logic [4:0] EV_PRES = 5'b00100;
    localparam logic [4:0] EV_DEC  = 5'b00010;
    localparam logic [4:0] EV_UNIT = 5'b00001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 0, tref_ev = 0, sref_ev = 0, pres_ev = 0, dec_ev = 0, unit_ev = 0;
    logic flag_clr = 0, cfg_we = 0;
    logic [1:0] cfg_sel = '0;
    logic [LW-1:0] cfg_data = '0;
    logic [4:0] viol_flag;
    logic [5*VW-1:0] viol_cnt;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ts_gap_monitor u_ts_gap_monitor (
        .clk(clk), .rst(rst), .tick_en(tick_en), .tref_ev(tref_ev),
        .sref_ev(sref_ev), .pres_ev(pres_ev), .dec_ev(dec_ev),
        .unit_ev(unit_ev), .flag_clr(flag_clr), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .viol_flag(viol_flag),
        .viol_cnt(viol_cnt)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cnt_of(input int k);
        return int'(viol_cnt[k*VW +: VW]);
    endfunction

    task automatic step(input logic t, input logic [4:0] ev, input logic clr);
        tick_en = t;
        {tref_ev, sref_ev, pres_ev, dec_ev, unit_ev} = ev;
        flag_clr = clr;
        @(negedge clk);
        tick_en = 0;
        {tref_ev, sref_ev, pres_ev, dec_ev, unit_ev} = '0;
        flag_clr = 0;
    endtask

    task automatic write_lim(input logic [1:0] sel, input int val);
        cfg_we = 1;
        cfg_sel = sel;
        cfg_data = LW'(val);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Sweep gaps 0..lim+3 between two events of kind k, ticking on alternate cycles.
    task automatic sweep(input int k, input int lim, input string req,
                         input logic [4:0] ev_a, input logic [4:0] ev_b);
        int base;
        int nviol;
        base = cnt_of(k);
        nviol = 0;
        for (int g = 0; g <= lim + 3; g++) begin
            step(0, ev_a, 0);
            for (int i = 1; i <= g; i++) begin
                step(1, '0, 0);
                check(req, int'(viol_flag[k]), (i > lim) ? 1 : 0);
                step(0, '0, 0);
            end
            if (g > lim) nviol++;
            step(0, (g % 2 == 1) ? ev_b : ev_a, 0);
            step(0, '0, 1);
            check("R10 clear", int'(viol_flag[k]), 0);
        end
        check("R9 R11 one count per overdue gap", cnt_of(k), base + nviol);
    endtask

    initial begin
        int base3;
        int base4;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check("R1 flags", int'(viol_flag), 0);
        for (int k = 0; k < 5; k++) check("R1 counter", cnt_of(k), 0);

        // R8 unarmed timers never fire
        for (int i = 0; i < 40; i++) step(1, '0, 0);
        check("R8 no event yet", int'(viol_flag), 0);

        // R7 default limits: 9000 for transport reference, 63000 for stamps
        step(0, EV_TREF | EV_PRES, 0);
        for (int i = 1; i <= 63001; i++) begin
            step(1, '0, 0);
            if (i == 9000)  check("R7 R2 default 9000 not yet", int'(viol_flag[0]), 0);
            if (i == 9001)  check("R7 R2 default 9000 crossed", int'(viol_flag[0]), 1);
            if (i == 63000) check("R7 R4 default 63000 not yet", int'(viol_flag[2]), 0);
            if (i == 63001) check("R7 R4 default 63000 crossed", int'(viol_flag[2]), 1);
        end
        check("R8 stream reference unarmed", int'(viol_flag[1]), 0);
        check("R9 single default crossing", cnt_of(0), 1);
        check("R12 flag one edge after tick", cnt_of(2), 1);
        step(0, '0, 1);
        check("R10 clear all", int'(viol_flag), 0);

        // R7 small limits; select 3 must be ignored
        write_lim(2'd0, 5);
        write_lim(2'd1, 7);
        write_lim(2'd2, 4);
        write_lim(2'd3, 1);

        sweep(0, 5, "R2 transport gap", EV_TREF, EV_TREF);
        sweep(1, 7, "R3 stream gap", EV_SREF, EV_SREF);
        sweep(2, 4, "R4 stamp gap", EV_PRES, EV_DEC);

        // R2 restart in the cycle of the crossing tick
        step(0, EV_TREF, 1);
        for (int i = 0; i < 5; i++) step(1, '0, 0);
        step(1, EV_TREF, 0);
        check("R2 event on crossing tick", int'(viol_flag[0]), 0);
        for (int i = 0; i < 5; i++) step(1, '0, 0);
        check("R2 restarted gap at limit", int'(viol_flag[0]), 0);
        step(1, '0, 0);
        check("R2 restarted gap crossed", int'(viol_flag[0]), 1);

        // R5 R6 every pairing of presentation, decode and unit strobes
        step(0, '0, 1);
        base3 = cnt_of(3);
        base4 = cnt_of(4);
        for (int c = 0; c < 8; c++) begin
            step(0, {2'b00, c[0], c[1], c[2]}, 0);
            check("R5 decode without presentation", int'(viol_flag[3]),
                  (c[1] && !c[0]) ? 1 : 0);
            check("R6 unit without stamp", int'(viol_flag[4]),
                  (c[2] && !c[0] && !c[1]) ? 1 : 0);
            step(0, '0, 1);
        end
        check("R11 decode count", cnt_of(3), base3 + 2);
        check("R11 unit count", cnt_of(4), base4 + 1);

        // R10 stickiness, clear versus same-cycle violation
        step(0, EV_UNIT, 0);
        for (int i = 0; i < 6; i++) step(0, '0, 0);
        check("R10 held without clear", int'(viol_flag[4]), 1);
        step(0, EV_UNIT, 1);
        check("R10 violation wins over clear", int'(viol_flag[4]), 1);
        step(0, '0, 1);
        check("R10 cleared", int'(viol_flag[4]), 0);

        // R11 saturation
        for (int i = 0; i < 300; i++) step(0, EV_UNIT, 0);
        check("R11 saturates at 255", cnt_of(4), 255);
        step(0, '0, 1);
        check("R11 clear leaves counter", cnt_of(4), 255);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule